// File: doc/BRIEF.md
# Peripheral Access Firewall Controller

This block sits beside an on-chip interconnect and decides, for each of up to `NUM_SLOTS` peripheral slots, whether a given requester may reach that peripheral. Each slot carries three attribute flags: secure-only, privileged-only and configuration-locked. Each slot also carries a compartment configuration word and a hardware semaphore. All of this state is programmed and read back through a simple word-addressed register bus.

The interconnect presents a slot number together with the requester's secure flag, privileged flag and 3-bit compartment ID on the check port. The block answers allow or deny in the same cycle. The decision combines four rules: secure filtering, privilege filtering, a fixed owning compartment, and ownership of the slot's semaphore.

Software can freeze a single slot through the lock flags. It can also freeze the whole per-slot configuration through a sticky global lock in the control word. Semaphores stay usable under both kinds of lock, so compartments can still hand a shared peripheral back and forth.

Top module: `periph_fw_ctrl`

## Requirements
- R1: After reset every readable register returns 0, except the two information words. With this state, the check port allows any in-range slot for any requester.
- R2: Slot n's secure flag is bit n%32 of the word at 0x010+4*(n/32), and its privileged flag is the same bit of the word at 0x030+4*(n/32). A written flag reads back as written. A non-secure requester is denied on a slot whose secure flag is set, and an unprivileged requester is denied on a slot whose privileged flag is set.
- R3: The compartment word of slot n is at 0x100+8*n. Its fields are: bit 0 filter enable, bit 1 semaphore mode, bits 6:4 owner ID, bit 10 word lock, and bits 23:16 a whitelist with bit 16+c standing for compartment c. With filtering off, the secure and privilege rules alone decide. With filtering on and semaphore mode off, only the requester whose ID equals the owner ID is allowed.
- R4: With filtering and semaphore mode both on, a requester is allowed only if it is on the whitelist and currently holds the slot's semaphore.
- R5: The semaphore word of slot n is at 0x104+8*n and reads as bit 0 held and bits 6:4 holder ID. Writing bit 0 = 1 takes the semaphore for the bus compartment only when the semaphore is free and that compartment is on the whitelist; otherwise nothing changes.
- R6: Writing bit 0 = 0 to a semaphore word frees it, and the word then reads 0, only when the bus compartment is the holder. Any other release leaves the word unchanged.
- R7: The lock flags are at 0x050+4*(n/32), bit n%32. They are write-one-to-set, writing 0 never clears them, and only reset does. A locked slot ignores writes to its secure flag, privileged flag and compartment word, while its neighbours stay writable.
- R8: Once a compartment word has bit 10 set, further writes to that word are ignored.
- R9: Writing bit 0 = 1 to the control word at 0x000 sets a global lock, which reads back as 1 and cannot be cleared. After that, writes to the secure, privileged and lock flags and to all compartment words are ignored, while semaphore take and release still work.
- R10: Slot numbers at or above NUM_SLOTS do not exist. Their flag bits and words read 0, writes to them have no effect, and the check port denies them.
- R11: The word at 0xFF8 reads NUM_SLOTS in bits 15:0. The word at 0xFFC reads 0x111, which flags compartment filtering in bits 3:0, secure filtering in bits 7:4 and privilege filtering in bits 11:8.
- R12: Read data appears on `bus_rdata` at the clock edge that samples `bus_rd` and is held until the next read. A register write changes the check-port answer from that same edge on, because the check path has no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_cid | input | 3 | Compartment ID of the bus master, used by semaphore take and release |
| bus_rdata | output | 32 | Registered read data |
| chk_id | input | ID_W | Slot number being checked |
| chk_sec | input | 1 | Requester is secure |
| chk_priv | input | 1 | Requester is privileged |
| chk_cid | input | 3 | Requester compartment ID |
| chk_allow | output | 1 | Access granted |

## Verification
There are two kinds of result, each due at a known time. A read result is due one rising edge after the strobe. A change in the check-port answer is due the moment the writing edge has passed, since the decision path holds no register. The bench drives every stimulus on the falling edge and samples read data at the falling edge after the capturing rising edge. For the check port, it samples 1 ns after setting the inputs. One check samples the answer before and after a single write edge, to show that the answer moves exactly at that edge.

// File: rtl/fw_pkg.sv
// fw_pkg: shared constants, field positions and slot record types for the
// peripheral access firewall. Assumes 32-bit register words and 3-bit
// compartment IDs.
package fw_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int CID_W   = 3;
    localparam int NUM_CID = 1 << CID_W;

    // register map anchors (byte addresses)
    localparam logic [ADDR_W-1:0] A_CTRL      = 12'h000;
    localparam logic [ADDR_W-1:0] A_SEC       = 12'h010;
    localparam logic [ADDR_W-1:0] A_PRIV      = 12'h030;
    localparam logic [ADDR_W-1:0] A_LOCK      = 12'h050;
    localparam logic [ADDR_W-1:0] A_SLOT      = 12'h100;
    localparam logic [ADDR_W-1:0] A_INFO_CNT  = 12'hFF8;
    localparam logic [ADDR_W-1:0] A_INFO_FEAT = 12'hFFC;
    localparam logic [DATA_W-1:0] FEAT_WORD   = 32'h0000_0111;

    // compartment word field positions
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_SEM_BIT  = 1;
    localparam int CFG_OWN_LSB  = 4;
    localparam int CFG_LOCK_BIT = 10;
    localparam int CFG_WL_LSB   = 16;

    // semaphore word field positions
    localparam int SEM_HELD_BIT = 0;
    localparam int SEM_OWN_LSB  = 4;

    typedef struct packed {
        logic [NUM_CID-1:0] wlist;
        logic               lock;
        logic [CID_W-1:0]   owner;
        logic               sem_mode;
        logic               filt_en;
    } slot_cfg_t;

    typedef struct packed {
        logic [CID_W-1:0] owner;
        logic             held;
    } sem_t;

    function automatic logic [DATA_W-1:0] cfg_to_word(input slot_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFG_EN_BIT]                = c.filt_en;
        w[CFG_SEM_BIT]               = c.sem_mode;
        w[CFG_OWN_LSB +: CID_W]      = c.owner;
        w[CFG_LOCK_BIT]              = c.lock;
        w[CFG_WL_LSB +: NUM_CID]     = c.wlist;
        return w;
    endfunction

    function automatic slot_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        slot_cfg_t c;
        c.filt_en  = w[CFG_EN_BIT];
        c.sem_mode = w[CFG_SEM_BIT];
        c.owner    = w[CFG_OWN_LSB +: CID_W];
        c.lock     = w[CFG_LOCK_BIT];
        c.wlist    = w[CFG_WL_LSB +: NUM_CID];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] sem_to_word(input sem_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SEM_HELD_BIT]          = s.held;
        w[SEM_OWN_LSB +: CID_W]  = s.owner;
        return w;
    endfunction
endpackage

// File: rtl/fw_flag_bank.sv
// fw_flag_bank: one flag per slot, packed 32 to a register word.
// STICKY=1 makes writes set-only (cleared by reset alone); STICKY=0 makes
// them plain overwrites. A slot whose hold bit is high ignores the write.
// Assumes wr_word addresses an implemented word only when wr_en is high.
module fw_flag_bank #(
    parameter int NUM_SLOTS = 128,
    parameter int WORD_W    = 2,
    parameter bit STICKY    = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic [31:0]          wr_data,
    input  logic [NUM_SLOTS-1:0] hold,
    output logic [NUM_SLOTS-1:0] bits
);
    logic [NUM_SLOTS-1:0] sel;
    logic [NUM_SLOTS-1:0] din;
    logic [NUM_SLOTS-1:0] bits_d;

    // select the slots covered by the addressed word and not held
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            sel[s] = wr_en && (int'(wr_word) == s / 32) && !hold[s];
            din[s] = wr_data[s % 32];
        end
    end

    // write policy chosen by parameter
    generate
        if (STICKY) begin : g_set_only
            assign bits_d = bits | (sel & din);
        end else begin : g_overwrite
            assign bits_d = (bits & ~sel) | (sel & din);
        end
    endgenerate

    // flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= bits_d;
    end
endmodule

// File: rtl/fw_slot_table.sv
// fw_slot_table: per-slot compartment configuration and semaphore state.
// Configuration writes respect the global lock, the slot lock flag and the
// word's own lock field; semaphore operations respect only the whitelist and
// ownership. Assumes idx is in range whenever a strobe is high.
module fw_slot_table import fw_pkg::*; #(
    parameter int NUM_SLOTS = 128,
    parameter int SLOT_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic                       sem_wr,
    input  logic [SLOT_W-1:0]          idx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [CID_W-1:0]           cid,
    input  logic                       glock,
    input  logic [NUM_SLOTS-1:0]       slot_lock,
    output slot_cfg_t [NUM_SLOTS-1:0]  cfg_q,
    output sem_t      [NUM_SLOTS-1:0]  sem_q
);
    // configuration words and semaphores, updated for the addressed slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sem_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (cfg_wr && int'(idx) == s && !glock && !slot_lock[s] && !cfg_q[s].lock)
                    cfg_q[s] <= word_to_cfg(wdata);
                if (sem_wr && int'(idx) == s) begin
                    if (wdata[SEM_HELD_BIT]) begin
                        if (!sem_q[s].held && cfg_q[s].wlist[cid]) begin
                            sem_q[s].held  <= 1'b1;
                            sem_q[s].owner <= cid;
                        end
                    end else if (sem_q[s].held && sem_q[s].owner == cid) begin
                        sem_q[s] <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fw_access_check.sv
// fw_access_check: combinational allow/deny for one request. Applies the
// secure rule, the privilege rule, then either the owner rule or the
// semaphore rule when compartment filtering is on. Slots at or above
// NUM_SLOTS are always denied.
module fw_access_check import fw_pkg::*; #(
    parameter int NUM_SLOTS = 128,
    parameter int SLOT_W    = 7,
    parameter int ID_W      = 8
) (
    input  logic [ID_W-1:0]            chk_id,
    input  logic                       chk_sec,
    input  logic                       chk_priv,
    input  logic [CID_W-1:0]           chk_cid,
    input  logic [NUM_SLOTS-1:0]       sec_bits,
    input  logic [NUM_SLOTS-1:0]       priv_bits,
    input  slot_cfg_t [NUM_SLOTS-1:0]  cfg_q,
    input  sem_t      [NUM_SLOTS-1:0]  sem_q,
    output logic                       allow
);
    localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_SLOTS);

    logic              in_range;
    logic [SLOT_W-1:0] sel;
    slot_cfg_t         c;
    sem_t              s;
    logic              sec_ok, priv_ok, cid_ok;

    // pick the slot record and evaluate each rule
    always_comb begin
        in_range = ({1'b0, chk_id} < LIMIT);
        sel      = in_range ? chk_id[SLOT_W-1:0] : '0;
        c        = cfg_q[sel];
        s        = sem_q[sel];
        sec_ok   = chk_sec  || !sec_bits[sel];
        priv_ok  = chk_priv || !priv_bits[sel];
        if (!c.filt_en)      cid_ok = 1'b1;
        else if (c.sem_mode) cid_ok = c.wlist[chk_cid] && s.held && (s.owner == chk_cid);
        else                 cid_ok = (c.owner == chk_cid);
        allow = in_range && sec_ok && priv_ok && cid_ok;
    end
endmodule

// File: rtl/periph_fw_ctrl.sv
// periph_fw_ctrl: register-programmed peripheral firewall. Decodes the
// register bus, holds the global lock, instantiates the three flag banks,
// the slot table and the access checker, and registers read data.
// Assumes NUM_SLOTS <= 128 so the slot region stays below the info words,
// and ID_W >= $clog2(NUM_SLOTS).
module periph_fw_ctrl import fw_pkg::*; #(
    parameter int NUM_SLOTS = 128,
    parameter int ID_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [2:0]        bus_cid,
    output logic [31:0]       bus_rdata,
    input  logic [ID_W-1:0]   chk_id,
    input  logic              chk_sec,
    input  logic              chk_priv,
    input  logic [2:0]        chk_cid,
    output logic              chk_allow
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int NWORDS = (NUM_SLOTS + 31) / 32;
    localparam int WORD_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(4 * NWORDS);
    localparam logic [ADDR_W-1:0] SLOT_SPAN = ADDR_W'(8 * NUM_SLOTS);

    // window test and word index helpers
    function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input logic [ADDR_W-1:0] span);
        return (a >= base) && ((a - base) < span);
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] base);
        return WORD_W'((a - base) >> 2);
    endfunction

    logic                       hit_ctrl, hit_sec, hit_priv, hit_lock, hit_slot;
    logic [WORD_W-1:0]          w_sec, w_priv, w_lock;
    logic [SLOT_W-1:0]          slot_idx;
    logic                       slot_is_sem;
    logic                       glock_q;
    logic [NUM_SLOTS-1:0]       sec_bits, priv_bits, lock_bits;
    logic [NUM_SLOTS-1:0]       attr_hold, lock_hold;
    slot_cfg_t [NUM_SLOTS-1:0]  cfg_q;
    sem_t      [NUM_SLOTS-1:0]  sem_q;
    logic [32*NWORDS-1:0]       sec_pad, priv_pad, lock_pad;
    logic [DATA_W-1:0]          rd_mux;

    // address decode shared by reads and writes
    always_comb begin
        hit_ctrl    = (bus_addr == A_CTRL);
        hit_sec     = in_win(bus_addr, A_SEC,  BANK_SPAN);
        hit_priv    = in_win(bus_addr, A_PRIV, BANK_SPAN);
        hit_lock    = in_win(bus_addr, A_LOCK, BANK_SPAN);
        hit_slot    = in_win(bus_addr, A_SLOT, SLOT_SPAN);
        w_sec       = word_of(bus_addr, A_SEC);
        w_priv      = word_of(bus_addr, A_PRIV);
        w_lock      = word_of(bus_addr, A_LOCK);
        slot_idx    = SLOT_W'((bus_addr - A_SLOT) >> 3);
        slot_is_sem = bus_addr[2];
    end

    // sticky global configuration lock
    always_ff @(posedge clk) begin
        if (!rst_n)                                  glock_q <= 1'b0;
        else if (bus_wr && hit_ctrl && bus_wdata[0]) glock_q <= 1'b1;
    end

    // write holds: attributes honour slot and global locks, lock flags only global
    assign attr_hold = lock_bits | {NUM_SLOTS{glock_q}};
    assign lock_hold = {NUM_SLOTS{glock_q}};

    fw_flag_bank #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .STICKY(1'b0)) u_sec (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit_sec), .wr_word(w_sec),
        .wr_data(bus_wdata), .hold(attr_hold), .bits(sec_bits));

    fw_flag_bank #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .STICKY(1'b0)) u_priv (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit_priv), .wr_word(w_priv),
        .wr_data(bus_wdata), .hold(attr_hold), .bits(priv_bits));

    fw_flag_bank #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .STICKY(1'b1)) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit_lock), .wr_word(w_lock),
        .wr_data(bus_wdata), .hold(lock_hold), .bits(lock_bits));

    fw_slot_table #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(bus_wr && hit_slot && !slot_is_sem),
        .sem_wr(bus_wr && hit_slot && slot_is_sem),
        .idx(slot_idx), .wdata(bus_wdata), .cid(bus_cid),
        .glock(glock_q), .slot_lock(lock_bits),
        .cfg_q(cfg_q), .sem_q(sem_q));

    fw_access_check #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ID_W(ID_W)) u_check (
        .chk_id(chk_id), .chk_sec(chk_sec), .chk_priv(chk_priv), .chk_cid(chk_cid),
        .sec_bits(sec_bits), .priv_bits(priv_bits), .cfg_q(cfg_q), .sem_q(sem_q),
        .allow(chk_allow));

    // zero-extend the banks to whole words for readback
    assign sec_pad  = (32*NWORDS)'(sec_bits);
    assign priv_pad = (32*NWORDS)'(priv_bits);
    assign lock_pad = (32*NWORDS)'(lock_bits);

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)                     rd_mux = {31'b0, glock_q};
        else if (hit_sec)                 rd_mux = sec_pad[32*int'(w_sec) +: 32];
        else if (hit_priv)                rd_mux = priv_pad[32*int'(w_priv) +: 32];
        else if (hit_lock)                rd_mux = lock_pad[32*int'(w_lock) +: 32];
        else if (hit_slot)                rd_mux = slot_is_sem ? sem_to_word(sem_q[slot_idx])
                                                               : cfg_to_word(cfg_q[slot_idx]);
        else if (bus_addr == A_INFO_CNT)  rd_mux = DATA_W'(NUM_SLOTS);
        else if (bus_addr == A_INFO_FEAT) rd_mux = FEAT_WORD;
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/fw_ctrl_checker.sv
// fw_ctrl_checker: temporal properties of the firewall, attached to every
// periph_fw_ctrl instance via bind. Observes lock state, the flag banks,
// the configuration table and the check port.
module fw_ctrl_checker import fw_pkg::*; #(
    parameter int NUM_SLOTS = 128,
    parameter int ID_W      = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       glock,
    input logic [NUM_SLOTS-1:0]       sec_bits,
    input logic [NUM_SLOTS-1:0]       priv_bits,
    input logic [NUM_SLOTS-1:0]       lock_bits,
    input slot_cfg_t [NUM_SLOTS-1:0]  cfg_q,
    input logic                       bus_rd,
    input logic [11:0]                bus_addr,
    input logic [31:0]                bus_rdata,
    input logic [ID_W-1:0]            chk_id,
    input logic                       chk_sec,
    input logic                       chk_priv,
    input logic                       chk_allow
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_SLOTS);

    logic              in_rng;
    logic [SLOT_W-1:0] sel;
    assign in_rng = ({1'b0, chk_id} < LIMIT);
    assign sel    = in_rng ? chk_id[SLOT_W-1:0] : '0;

    a_r9_glock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        glock |=> glock);

    a_r9_glock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        glock |=> ($stable(sec_bits) && $stable(priv_bits) && $stable(lock_bits) && $stable(cfg_q)));

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));

    a_r2_sec_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rng && chk_allow && !chk_sec) |-> !sec_bits[sel]);

    a_r2_priv_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rng && chk_allow && !chk_priv) |-> !priv_bits[sel]);

    a_r10_oob_deny: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rng |-> !chk_allow);

    a_r11_count_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_INFO_CNT) |=> (bus_rdata == 32'(NUM_SLOTS)));
endmodule

bind periph_fw_ctrl fw_ctrl_checker #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_fw_chk (
    .clk(clk), .rst_n(rst_n), .glock(glock_q),
    .sec_bits(sec_bits), .priv_bits(priv_bits), .lock_bits(lock_bits), .cfg_q(cfg_q),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .chk_id(chk_id), .chk_sec(chk_sec), .chk_priv(chk_priv), .chk_allow(chk_allow));

// File: tb/periph_fw_ctrl_tb.sv
// Bench for periph_fw_ctrl with 40 slots (two flag words, the second partly
// implemented). Inputs change on falling edges; results are sampled at the
// following falling edge (reads) or 1 ns after the inputs (check port).
module periph_fw_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS         = 40;
    localparam int IDW        = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [2:0]      bus_cid = '0;
    logic [31:0]     bus_rdata;
    logic [IDW-1:0]  chk_id = '0;
    logic            chk_sec = 1'b0, chk_priv = 1'b0;
    logic [2:0]      chk_cid = '0;
    logic            chk_allow;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_fw_ctrl #(.NUM_SLOTS(NS), .ID_W(IDW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cid(bus_cid),
        .bus_rdata(bus_rdata), .chk_id(chk_id), .chk_sec(chk_sec),
        .chk_priv(chk_priv), .chk_cid(chk_cid), .chk_allow(chk_allow));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input int c);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cid = 3'(c);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic probe(input int id, input bit s, input bit p, input int c, output logic a);
        @(negedge clk);
        chk_id = IDW'(id); chk_sec = s; chk_priv = p; chk_cid = 3'(c);
        #1 a = chk_allow;
    endtask

    function automatic logic [11:0] cfg_a(input int id);
        return 12'h100 + 12'(8 * id);
    endfunction

    function automatic logic [11:0] sem_a(input int id);
        return 12'h104 + 12'(8 * id);
    endfunction

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check("R1 ctrl", 12'h000, 32'h0);
        read_check("R1 sec word0", 12'h010, 32'h0);
        read_check("R1 lock word1", 12'h054, 32'h0);
        read_check("R1 cfg slot5", cfg_a(5), 32'h0);
        read_check("R1 sem slot5", sem_a(5), 32'h0);
        for (int id = 0; id < NS; id += 7) begin
            probe(id, 1'b0, 1'b0, id % 8, a);
            check("R1 allow after reset", 32'(a), 32'h1);
        end

        // R11 information words
        read_check("R11 slot count", 12'hFF8, 32'(NS));
        read_check("R11 feature flags", 12'hFFC, 32'h111);

        // R2 flag banks and secure/privileged rules
        bus_write(12'h010, 32'h0000_00A5, 0);
        bus_write(12'h030, 32'h0000_00C3, 0);
        read_check("R2 sec readback", 12'h010, 32'h0000_00A5);
        read_check("R2 priv readback", 12'h030, 32'h0000_00C3);
        for (int id = 0; id < 10; id++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 2; p++) begin
                    bit sb, pb, ex;
                    sb = (32'hA5 >> id) & 1;
                    pb = (32'hC3 >> id) & 1;
                    ex = (s != 0 || !sb) && (p != 0 || !pb);
                    probe(id, s[0], p[0], 0, a);
                    check($sformatf("R2 slot%0d sec%0d priv%0d", id, s, p), 32'(a), 32'(ex));
                end
            end
        end

        // R10 second flag word only partly implemented
        bus_write(12'h014, 32'hFFFF_FFFF, 0);
        read_check("R10 sec word1 masked", 12'h014, 32'h0000_00FF);
        probe(35, 1'b0, 1'b1, 0, a);
        check("R2 slot35 non-secure denied", 32'(a), 32'h0);
        probe(35, 1'b1, 1'b1, 0, a);
        check("R2 slot35 secure allowed", 32'(a), 32'h1);

        // R3 static owner filtering
        bus_write(cfg_a(12), 32'h00FF_0051, 0);
        read_check("R3 cfg readback", cfg_a(12), 32'h00FF_0051);
        for (int c = 0; c < 8; c++) begin
            probe(12, 1'b1, 1'b1, c, a);
            check($sformatf("R3 owner rule cid%0d", c), 32'(a), 32'(c == 5));
        end

        // R4, R5, R6 semaphore mode, whitelist {2,6}
        bus_write(cfg_a(20), 32'h0044_0003, 0);
        for (int c = 0; c < 8; c++) begin
            probe(20, 1'b1, 1'b1, c, a);
            check($sformatf("R4 free semaphore denies cid%0d", c), 32'(a), 32'h0);
        end
        bus_write(sem_a(20), 32'h1, 3);
        read_check("R5 take by non-listed cid ignored", sem_a(20), 32'h0);
        bus_write(sem_a(20), 32'h1, 2);
        read_check("R5 take by cid2", sem_a(20), 32'h21);
        for (int c = 0; c < 8; c++) begin
            probe(20, 1'b1, 1'b1, c, a);
            check($sformatf("R4 holder rule cid%0d", c), 32'(a), 32'(c == 2));
        end
        bus_write(sem_a(20), 32'h1, 6);
        read_check("R5 take while held ignored", sem_a(20), 32'h21);
        bus_write(sem_a(20), 32'h0, 6);
        read_check("R6 release by non-holder ignored", sem_a(20), 32'h21);
        bus_write(sem_a(20), 32'h0, 2);
        read_check("R6 release by holder", sem_a(20), 32'h0);
        probe(20, 1'b1, 1'b1, 2, a);
        check("R4 released semaphore denies", 32'(a), 32'h0);
        bus_write(sem_a(20), 32'h1, 6);
        read_check("R5 take by cid6", sem_a(20), 32'h61);
        probe(20, 1'b1, 1'b1, 6, a);
        check("R4 new holder allowed", 32'(a), 32'h1);

        // R7 per-slot lock on slot 12
        bus_write(12'h050, 32'h0000_1000, 0);
        read_check("R7 lock set", 12'h050, 32'h0000_1000);
        bus_write(12'h050, 32'h0, 0);
        read_check("R7 lock not cleared by zero", 12'h050, 32'h0000_1000);
        bus_write(12'h010, 32'hFFFF_FFFF, 0);
        read_check("R7 locked slot sec flag held", 12'h010, 32'hFFFF_EFFF);
        probe(12, 1'b0, 1'b1, 5, a);
        check("R7 locked slot still non-secure", 32'(a), 32'h1);
        bus_write(cfg_a(12), 32'h0, 0);
        read_check("R7 locked cfg held", cfg_a(12), 32'h00FF_0051);
        bus_write(cfg_a(13), 32'h0000_0011, 0);
        read_check("R7 neighbour cfg writable", cfg_a(13), 32'h0000_0011);
        bus_write(12'h010, 32'h0, 0);
        read_check("R7 sec word0 cleared", 12'h010, 32'h0);

        // R8 word lock bit in the compartment word
        bus_write(cfg_a(14), 32'h0000_0401, 0);
        read_check("R8 cfg with lock", cfg_a(14), 32'h0000_0401);
        bus_write(cfg_a(14), 32'h0, 0);
        read_check("R8 self-locked cfg held", cfg_a(14), 32'h0000_0401);
        probe(14, 1'b1, 1'b1, 0, a);
        check("R8 owner0 allowed", 32'(a), 32'h1);
        probe(14, 1'b1, 1'b1, 1, a);
        check("R8 cid1 denied", 32'(a), 32'h0);

        // R10 non-existent slots
        bus_write(cfg_a(40), 32'h0000_0051, 0);
        read_check("R10 cfg slot40 reads zero", cfg_a(40), 32'h0);
        read_check("R10 sem slot40 reads zero", sem_a(40), 32'h0);
        bus_write(12'h018, 32'hFFFF_FFFF, 0);
        read_check("R10 sec word2 reads zero", 12'h018, 32'h0);
        probe(40, 1'b1, 1'b1, 0, a);
        check("R10 slot40 denied", 32'(a), 32'h0);
        probe(200, 1'b1, 1'b1, 0, a);
        check("R10 slot200 denied", 32'(a), 32'h0);

        // R12 check port follows a write at the writing edge
        @(negedge clk);
        chk_id = 8'd30; chk_sec = 1'b0; chk_priv = 1'b1; chk_cid = 3'd0;
        #1 check("R12 before write", 32'(chk_allow), 32'h1);
        bus_write(12'h010, 32'h4000_0000, 0);
        check("R12 right after write edge", 32'(chk_allow), 32'h0);
        read_check("R12 read data after one edge", 12'h010, 32'h4000_0000);

        // R9 global lock
        bus_write(12'h000, 32'h1, 0);
        read_check("R9 lock reads one", 12'h000, 32'h1);
        bus_write(12'h000, 32'h0, 0);
        read_check("R9 lock not clearable", 12'h000, 32'h1);
        bus_write(12'h010, 32'hFFFF_FFFF, 0);
        read_check("R9 sec frozen", 12'h010, 32'h4000_0000);
        bus_write(12'h050, 32'hFFFF_FFFF, 0);
        read_check("R9 lock flags frozen", 12'h050, 32'h0000_1000);
        bus_write(cfg_a(13), 32'h0, 0);
        read_check("R9 cfg frozen", cfg_a(13), 32'h0000_0011);
        bus_write(sem_a(20), 32'h0, 6);
        read_check("R9 semaphore release works", sem_a(20), 32'h0);
        bus_write(sem_a(20), 32'h1, 2);
        read_check("R9 semaphore take works", sem_a(20), 32'h21);

        finish_run();
    end
endmodule